// File: doc/BRIEF.md
# Boundary Scan Cell Chain with Preload Stage

This block is the data side of a test access port's boundary register. A run of scan cells, one for each input pin and one for each output pin, can take a snapshot of the pin ring, move it out serially toward the test data output, and take in a new pattern from the test data input. Each output cell also has a parallel update stage. That stage holds a pattern loaded ahead of time. The pins use this pattern only when the external-test mode is active.

A test access port controller, which lies outside this block, supplies three single-cycle strobes: capture, shift and update. It also supplies a two-bit mode code taken from its instruction decode. In sample mode the pins stay under functional control, so a chip in normal operation can be observed and preloaded without disturbance. In high-impedance sample mode every output enable is forced low while the chain remains available for shifting. Everything runs on the test clock, with a synchronous active-high reset that stands for the controller's test-logic-reset state.

Top module: `bsr_chain`

## Requirements
- R1: The mode input uses code 00 for "chain not selected". In that mode the capture, shift and update strobes have no effect on the chain or on the update stage, and tdo keeps its value.
- R2: On a clock edge with capture_en high and mode 01, 10 or 11, every cell loads its pin's value as it is at that edge. An input cell loads pad_in. An output cell loads the value currently driven on pad_out.
- R3: On an edge with shift_en high and a selected mode, the chain moves one place toward tdo. tdi enters the most significant cell, and tdo always shows the least significant cell. If capture_en and shift_en are high together, capture wins.
- R4: On an edge with update_en high and a selected mode, the update stage copies the output cells of the chain. Capture and shift never change the update stage.
- R5: In mode 10 (external test), pad_out equals the update stage and every pad_oe bit is 1.
- R6: In mode 01 (sample/preload), pad_out and pad_oe equal func_out and func_oe, including after capture, shift and update.
- R7: In mode 11 (high-impedance sample), every pad_oe bit is 0, pad_out follows func_out, and the chain still captures and shifts.
- R8: While rst is high at an edge, the chain and the update stage clear to 0.
- R9: With the default OUT_NEAR_TDO = 1, output pin i sits at chain bit i and input pin j sits at chain bit NUM_OUT + j. With OUT_NEAR_TDO = 0, the input cells sit nearest tdo.
- R10: In mode 00, pad_out and pad_oe equal func_out and func_oe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high test-logic reset |
| mode | input | 2 | 00 off, 01 sample/preload, 10 external test, 11 high-impedance sample |
| capture_en | input | 1 | Capture strobe |
| shift_en | input | 1 | Shift strobe |
| update_en | input | 1 | Update strobe |
| tdi | input | 1 | Serial data in |
| pad_in | input | NUM_IN | Values seen on the input pins |
| func_out | input | NUM_OUT | Functional output data |
| func_oe | input | NUM_OUT | Functional output enables |
| tdo | output | 1 | Serial data out (least significant cell) |
| pad_out | output | NUM_OUT | Data toward the output pins |
| pad_oe | output | NUM_OUT | Enables toward the output pins |

## Verification
pad_out and pad_oe are combinational from mode, the functional inputs and the update stage. The bench therefore checks them one nanosecond after it drives new inputs, within the same cycle. A captured or shifted value becomes visible on tdo after the strobe's rising edge. The bench reads tdo just before each shift edge, so the k-th read gives chain bit k of the snapshot. An update appears on the pins right after its edge, and the bench checks the pins before the next strobe is driven.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

    typedef enum logic [1:0] {
        BSR_OFF    = 2'b00,
        BSR_SAMPLE = 2'b01,
        BSR_EXTEST = 2'b10,
        BSR_HIGHZ  = 2'b11
    } bsr_mode_e;

    typedef struct packed {
        logic capture;
        logic shift;
        logic update;
    } bsr_strobe_t;

    function automatic logic bsr_selected(input bsr_mode_e m);
        return m != BSR_OFF;
    endfunction

    function automatic bsr_strobe_t bsr_gate(input bsr_mode_e m, input logic c,
                                             input logic s, input logic u);
        bsr_strobe_t r;
        r.capture = c & bsr_selected(m);
        r.shift   = s & bsr_selected(m);
        r.update  = u & bsr_selected(m);
        return r;
    endfunction

endpackage

// File: rtl/bsr_cap_cell.sv
module bsr_cap_cell (
    input  logic clk,
    input  logic rst,
    input  logic cap_en,
    input  logic shf_en,
    input  logic par_d,
    input  logic ser_d,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)         q <= 1'b0;
        else if (cap_en) q <= par_d;
        else if (shf_en) q <= ser_d;
    end
endmodule

// File: rtl/bsr_upd_stage.sv
module bsr_upd_stage #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (en) q <= d;
    end
endmodule

// File: rtl/bsr_pin_drv.sv
module bsr_pin_drv
    import bsr_pkg::*;
#(
    parameter int W = 4
) (
    input  bsr_mode_e    mode,
    input  logic [W-1:0] func_out,
    input  logic [W-1:0] func_oe,
    input  logic [W-1:0] held,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe
);
    always_comb begin
        pad_out = func_out;
        pad_oe  = func_oe;
        case (mode)
            BSR_EXTEST: begin
                pad_out = held;
                pad_oe  = '1;
            end
            BSR_HIGHZ:  pad_oe = '0;
            default:    ;
        endcase
    end
endmodule

// File: rtl/bsr_chain.sv
module bsr_chain
    import bsr_pkg::*;
#(
    parameter int NUM_IN       = 4,
    parameter int NUM_OUT      = 4,
    parameter bit OUT_NEAR_TDO = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         mode,
    input  logic               capture_en,
    input  logic               shift_en,
    input  logic               update_en,
    input  logic               tdi,
    input  logic [NUM_IN-1:0]  pad_in,
    input  logic [NUM_OUT-1:0] func_out,
    input  logic [NUM_OUT-1:0] func_oe,
    output logic               tdo,
    output logic [NUM_OUT-1:0] pad_out,
    output logic [NUM_OUT-1:0] pad_oe
);
    localparam int CHAIN    = NUM_IN + NUM_OUT;
    localparam int OUT_BASE = OUT_NEAR_TDO ? 0 : NUM_IN;
    localparam int IN_BASE  = OUT_NEAR_TDO ? NUM_OUT : 0;

    bsr_mode_e   mode_e;
    bsr_strobe_t stb;
    logic [CHAIN-1:0]   cap_q;
    logic [CHAIN-1:0]   par_vec;
    logic [CHAIN-1:0]   ser_vec;
    logic [NUM_OUT-1:0] upd_q;

    assign mode_e  = bsr_mode_e'(mode);
    assign stb     = bsr_gate(mode_e, capture_en, shift_en, update_en);
    assign ser_vec = {tdi, cap_q[CHAIN-1:1]};
    assign tdo     = cap_q[0];

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_out_map
        assign par_vec[OUT_BASE + i] = pad_out[i];
    end
    for (genvar j = 0; j < NUM_IN; j++) begin : g_in_map
        assign par_vec[IN_BASE + j] = pad_in[j];
    end

    for (genvar k = 0; k < CHAIN; k++) begin : g_cell
        bsr_cap_cell u_cell (
            .clk    (clk),
            .rst    (rst),
            .cap_en (stb.capture),
            .shf_en (stb.shift),
            .par_d  (par_vec[k]),
            .ser_d  (ser_vec[k]),
            .q      (cap_q[k])
        );
    end

    bsr_upd_stage #(.W(NUM_OUT)) u_upd (
        .clk (clk),
        .rst (rst),
        .en  (stb.update),
        .d   (cap_q[OUT_BASE +: NUM_OUT]),
        .q   (upd_q)
    );

    bsr_pin_drv #(.W(NUM_OUT)) u_drv (
        .mode     (mode_e),
        .func_out (func_out),
        .func_oe  (func_oe),
        .held     (upd_q),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe)
    );
endmodule

// File: rtl/bsr_chain_chk.sv
module bsr_chain_chk #(
    parameter int NUM_IN       = 4,
    parameter int NUM_OUT      = 4,
    parameter bit OUT_NEAR_TDO = 1'b1
) (
    input logic                       clk,
    input logic                       rst,
    input logic [1:0]                 mode,
    input logic                       shift_en,
    input logic                       capture_en,
    input logic                       update_en,
    input logic                       tdi,
    input logic [NUM_OUT-1:0]         func_out,
    input logic [NUM_OUT-1:0]         func_oe,
    input logic [NUM_OUT-1:0]         pad_out,
    input logic [NUM_OUT-1:0]         pad_oe,
    input logic [NUM_IN+NUM_OUT-1:0]  cap_q,
    input logic [NUM_OUT-1:0]         upd_q
);
    localparam int CHAIN    = NUM_IN + NUM_OUT;
    localparam int OUT_BASE = OUT_NEAR_TDO ? 0 : NUM_IN;

    logic sel;
    assign sel = (mode != 2'b00);

    assert_unselected_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b00) |=> ($stable(cap_q) && $stable(upd_q)));

    assert_shift_entry_R3: assert property (@(posedge clk) disable iff (rst)
        (sel && shift_en && !capture_en) |=> (cap_q[CHAIN-1] == $past(tdi)));

    assert_update_copy_R4: assert property (@(posedge clk) disable iff (rst)
        (sel && update_en) |=> (upd_q == $past(cap_q[OUT_BASE +: NUM_OUT])));

    assert_update_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !(sel && update_en) |=> $stable(upd_q));

    assert_extest_drive_R5: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b10) |-> (pad_out == upd_q && (&pad_oe)));

    assert_sample_transparent_R6: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b01) |-> (pad_out == func_out && pad_oe == func_oe));

    assert_highz_R7: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b11) |-> (pad_oe == '0));

    assert_off_transparent_R10: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b00) |-> (pad_out == func_out && pad_oe == func_oe));
endmodule

bind bsr_chain bsr_chain_chk #(
    .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .OUT_NEAR_TDO(OUT_NEAR_TDO)
) u_chk (
    .clk(clk), .rst(rst), .mode(mode), .shift_en(shift_en),
    .capture_en(capture_en), .update_en(update_en), .tdi(tdi),
    .func_out(func_out), .func_oe(func_oe), .pad_out(pad_out),
    .pad_oe(pad_oe), .cap_q(cap_q), .upd_q(upd_q)
);

// File: tb/test_bsr_chain.sv
module test_bsr_chain;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode = 2'b10;
    logic       capture_en = 1'b0, shift_en = 1'b0, update_en = 1'b0, tdi = 1'b0;
    logic [3:0] pad_in = '0, func_out = '0, func_oe = '0;
    logic       tdo;
    logic [3:0] pad_out, pad_oe;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] model_chain = '0;
    logic [3:0] model_upd = '0;

    always #2.5 clk = ~clk;

    bsr_chain i_bsr_chain (
        .clk(clk), .rst(rst), .mode(mode), .capture_en(capture_en),
        .shift_en(shift_en), .update_en(update_en), .tdi(tdi),
        .pad_in(pad_in), .func_out(func_out), .func_oe(func_oe),
        .tdo(tdo), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    // {mode, pad_in, func_out, func_oe, tdi pattern}
    localparam logic [21:0] VEC [7] = '{
        {2'b01, 4'hA, 4'h3, 4'hF, 8'hC5},
        {2'b10, 4'h6, 4'h9, 4'h0, 8'h3E},
        {2'b11, 4'hF, 4'hC, 4'hF, 8'h71},
        {2'b00, 4'h5, 4'hA, 4'h3, 8'hFF},
        {2'b10, 4'h0, 4'h0, 4'hF, 8'h96},
        {2'b01, 4'h9, 4'h6, 4'h5, 8'h00},
        {2'b10, 4'h3, 4'hF, 4'h0, 8'hA5}
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic pulse_capture();
        capture_en = 1'b1; step(); capture_en = 1'b0;
    endtask

    task automatic pulse_update();
        update_en = 1'b1; step(); update_en = 1'b0;
    endtask

    task automatic shift_all(input logic [7:0] pat, output logic [7:0] got);
        for (int k = 0; k < 8; k++) begin
            tdi = pat[k];
            shift_en = 1'b1;
            got[k] = tdo;
            step();
        end
        shift_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] got;
        logic [3:0] exp_out, exp_oe;
        logic [1:0] m;
        #1;
        repeat (3) step();
        rst = 1'b0;
        // R8 reset state, R5 extest drive of a cleared update stage
        check("R8", "reset tdo", {7'd0, tdo}, 8'h00);
        check("R8", "reset pad_out", {4'd0, pad_out}, 8'h00);
        check("R5", "reset pad_oe", {4'd0, pad_oe}, 8'h0F);

        for (int v = 0; v < 7; v++) begin
            m        = VEC[v][21:20];
            mode     = m;
            pad_in   = VEC[v][19:16];
            func_out = VEC[v][15:12];
            func_oe  = VEC[v][11:8];
            #1;
            case (m)
                2'b10:   begin exp_out = model_upd; exp_oe = 4'hF;    end
                2'b11:   begin exp_out = func_out;  exp_oe = 4'h0;    end
                default: begin exp_out = func_out;  exp_oe = func_oe; end
            endcase
            // R5 extest, R6 sample, R7 high-z, R10 off
            check(m == 2'b10 ? "R5" : m == 2'b11 ? "R7" : m == 2'b01 ? "R6" : "R10",
                  "pad_out", {4'd0, pad_out}, {4'd0, exp_out});
            check(m == 2'b10 ? "R5" : m == 2'b11 ? "R7" : m == 2'b01 ? "R6" : "R10",
                  "pad_oe", {4'd0, pad_oe}, {4'd0, exp_oe});
            pulse_capture();
            if (m != 2'b00) model_chain = {pad_in, exp_out};
            shift_all(VEC[v][7:0], got);
            if (m != 2'b00) begin
                // R2 capture, R3 shift order, R9 pin placement
                check("R2", "captured chain (R3 R9)", got, model_chain);
                model_chain = VEC[v][7:0];
                pulse_update();
                model_upd = model_chain[3:0];
            end else begin
                // R1 strobes ignored: tdo holds chain bit 0
                check("R1", "tdo unselected", got, {8{model_chain[0]}});
                pulse_update();
            end
            if (m == 2'b01) begin
                #1;
                check("R6", "pins after preload", {pad_oe, pad_out}, {func_oe, func_out});
            end
        end

        // R1: update while unselected is ignored
        mode = 2'b01; #1;
        shift_all(8'h0C, got);
        mode = 2'b00; #1;
        pulse_update();
        mode = 2'b10; #1;
        check("R1", "update ignored when off", {4'd0, pad_out}, {4'd0, model_upd});

        // R4: capture and shift leave update stage alone
        pad_in = 4'h7; #1;
        pulse_capture();
        shift_all(8'hE3, got);
        check("R4", "update stage after capture/shift", {4'd0, pad_out}, {4'd0, model_upd});
        check("R2", "extest capture of driven pins", got, {4'h7, model_upd});

        // R3: capture wins over shift
        mode = 2'b01; pad_in = 4'hC; func_out = 4'hA; tdi = 1'b1;
        capture_en = 1'b1; shift_en = 1'b1;
        step();
        capture_en = 1'b0; shift_en = 1'b0;
        shift_all(8'h00, got);
        check("R3", "capture priority over shift", got, 8'hCA);

        // R7: chain still shifts under high-z sample
        mode = 2'b11; #1;
        shift_all(8'h5B, got);
        shift_all(8'h00, got);
        check("R7", "shift under high-z", got, 8'h5B);

        // R8: reset mid-run clears the update stage
        mode = 2'b01; #1;
        shift_all(8'hFF, got);
        pulse_update();
        mode = 2'b10; #1;
        check("R5", "extest after preload", {4'd0, pad_out}, 8'h0F);
        rst = 1'b1; step(); rst = 1'b0; #1;
        check("R8", "reset clears update stage", {4'd0, pad_out}, 8'h00);
        check("R8", "reset clears chain", {7'd0, tdo}, 8'h00);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule